// File: doc/BRIEF.md
# Single-Cycle 32-bit Integer Core

This block is a compact 32-bit processor core that completes every instruction in one clock period. On each rising edge it retires the instruction addressed by the program counter. The instruction is fetched from an internal word memory and decoded into a set of control points. The core then reads two registers, runs the ALU, optionally touches an internal data memory, writes back a result and selects the next program counter.

The instruction subset covers six instructions:

- unsigned register add and subtract
- OR with a zero-extended 16-bit immediate
- word load and word store with a sign-extended offset
- branch-if-equal with a sign-extended word offset

Separate control points choose:

- the destination register field (rd or rt)
- the second ALU operand (register or immediate)
- zero or sign extension of the immediate
- the write-back source (ALU or memory)
- the memory write
- the register write
- the branch

While the core is held in reset, the surrounding logic fills both memories through a side load port. The same select that steers that port also chooses which memory the observation port reads. A separate observation port reads any register. The core itself does not hold a load or a store behind any handshake.

Top module: `sc_core`

## Requirements
- R1: While rst_ni is low, pc_o is 0 and every register reads 0; asserting rst_ni low takes effect without waiting for a clock edge.
- R2: Opcode 0x00 with funct 0x21 writes R[rs] + R[rt], modulo 2^32, to register rd. Fields are op[31:26], rs[25:21], rt[20:16], rd[15:11] and funct[5:0].
- R3: Opcode 0x00 with funct 0x23 writes R[rs] - R[rt], modulo 2^32, to register rd.
- R4: Opcode 0x0D writes R[rs] | {16'b0, imm[15:0]} to register rt, and never to the register named by bits [15:11].
- R5: Opcode 0x23 writes to rt the data word at byte address R[rs] + sign-extended imm. The word index is address bits [9:2].
- R6: Opcode 0x2B stores R[rt] to the data word at R[rs] + sign-extended imm, at index bits [9:2]. It writes no register.
- R7: Opcode 0x04 sets the next PC to PC + 4 + (sign-extended imm << 2) when R[rs] == R[rt], and to PC + 4 otherwise.
- R8: A write that targets register 0 is dropped, so register 0 always reads 0.
- R9: Any opcode other than the six listed, and opcode 0x00 with a funct other than 0x21 or 0x23, writes no register and no memory, and advances the PC by 4.
- R10: Exactly one instruction retires per rising clock edge after reset is released. A non-branch instruction advances the PC by 4.
- R11: With load_en_i high, load_data_i is written on the clock edge to word load_addr_i of the instruction memory (load_sel_i = 0) or of the data memory (load_sel_i = 1). dbg_mem_data_o returns word dbg_mem_addr_i of the memory selected by load_sel_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_en_i | input | 1 | Side-port write enable |
| load_sel_i | input | 1 | Memory select: 0 instruction, 1 data |
| load_addr_i | input | MEM_AW | Side-port word index |
| load_data_i | input | 32 | Side-port write data |
| pc_o | output | 32 | Current program counter |
| dbg_reg_addr_i | input | 5 | Observation register number |
| dbg_reg_data_o | output | 32 | Observed register contents |
| dbg_mem_addr_i | input | MEM_AW | Observation memory word index |
| dbg_mem_data_o | output | 32 | Observed memory word |

## Verification
The bench preloads a program that puts a value with bit 15 set through the OR-immediate, so a design that sign-extends there leaves 0xFFFF8000 in r1 instead of 0x8000. The negative-offset load and the store both carry a non-zero bits [15:11] field, so a design with the destination select wrong writes r31 or overwrites r1. Writes aimed at r0, an unknown opcode and an unknown funct must each leave the register file untouched, and a decoder that defaults to a write corrupts r0, r7 or r11. A branch that is not taken, a branch that is taken forward, and a self-loop are traced cycle by cycle on pc_o, which exposes an offset that is not shifted or a wrong base address.

// File: rtl/core_pkg.sv
package core_pkg;
  localparam int XLEN = 32;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_ORI   = 6'h0D;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] FN_ADDU  = 6'h21;
  localparam logic [5:0] FN_SUBU  = 6'h23;

  typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_OR} alu_op_e;

  typedef struct packed {
    logic    valid;
    logic    dst_rd;      // 1: rd, 0: rt
    logic    src_imm;     // 1: immediate operand
    logic    ext_sign;    // 1: sign extend, 0: zero extend
    logic    wb_mem;      // 1: write back load data
    logic    mem_we;
    logic    reg_we;
    logic    branch;
    alu_op_e alu_op;
  } ctrl_t;
endpackage

// File: rtl/core_decoder.sv
module core_decoder
  import core_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [5:0]  op_i,
  input  logic [5:0]  funct_i,
  output ctrl_t       ctrl_o
);
  always_comb begin
    ctrl_o = '{valid: 1'b0, dst_rd: 1'b0, src_imm: 1'b0, ext_sign: 1'b0,
               wb_mem: 1'b0, mem_we: 1'b0, reg_we: 1'b0, branch: 1'b0,
               alu_op: ALU_ADD};
    unique case (op_i)
      OP_RTYPE: begin
        if (funct_i == FN_ADDU || funct_i == FN_SUBU) begin
          ctrl_o.valid  = 1'b1;
          ctrl_o.dst_rd = 1'b1;
          ctrl_o.reg_we = 1'b1;
          ctrl_o.alu_op = (funct_i == FN_SUBU) ? ALU_SUB : ALU_ADD;
        end
      end
      OP_ORI: begin
        ctrl_o.valid   = 1'b1;
        ctrl_o.src_imm = 1'b1;
        ctrl_o.reg_we  = 1'b1;
        ctrl_o.alu_op  = ALU_OR;
      end
      OP_LW: begin
        ctrl_o.valid    = 1'b1;
        ctrl_o.src_imm  = 1'b1;
        ctrl_o.ext_sign = 1'b1;
        ctrl_o.wb_mem   = 1'b1;
        ctrl_o.reg_we   = 1'b1;
      end
      OP_SW: begin
        ctrl_o.valid    = 1'b1;
        ctrl_o.src_imm  = 1'b1;
        ctrl_o.ext_sign = 1'b1;
        ctrl_o.mem_we   = 1'b1;
      end
      OP_BEQ: begin
        ctrl_o.valid    = 1'b1;
        ctrl_o.ext_sign = 1'b1;
        ctrl_o.branch   = 1'b1;
        ctrl_o.alu_op   = ALU_SUB;
      end
      default: ;
    endcase
  end

  a_r9_unknown_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_o.valid |-> !ctrl_o.reg_we && !ctrl_o.mem_we && !ctrl_o.branch);
  a_r6_store_no_regwr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o.mem_we |-> !ctrl_o.reg_we);
endmodule

// File: rtl/core_regfile.sv
module core_regfile #(
  parameter int DW   = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] wa_i,
  input  logic [DW-1:0] wd_i,
  input  logic [AW-1:0] ra_i,
  output logic [DW-1:0] ra_data_o,
  input  logic [AW-1:0] rb_i,
  output logic [DW-1:0] rb_data_o,
  input  logic [AW-1:0] rc_i,
  output logic [DW-1:0] rc_data_o
);
  logic [DW-1:0] regs_q [NREG];

  assign regs_q[0] = '0;

  for (genvar g = 1; g < NREG; g++) begin : g_row
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            regs_q[g] <= '0;
      else if (we_i && wa_i == AW'(g))        regs_q[g] <= wd_i;
    end
  end

  assign ra_data_o = regs_q[ra_i];
  assign rb_data_o = regs_q[rb_i];
  assign rc_data_o = regs_q[rc_i];

  a_r8_zero_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rc_i == '0) |-> (rc_data_o == '0));
  a_r2_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wa_i != '0) |=> regs_q[$past(wa_i)] == $past(wd_i));
endmodule

// File: rtl/core_alu.sv
module core_alu
  import core_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  alu_op_e       op_i,
  output logic [DW-1:0] y_o,
  output logic          zero_o
);
  always_comb begin
    unique case (op_i)
      ALU_SUB: y_o = a_i - b_i;
      ALU_OR:  y_o = a_i | b_i;
      default: y_o = a_i + b_i;
    endcase
  end
  assign zero_o = (y_o == '0);
endmodule

// File: rtl/core_wmem.sv
module core_wmem #(
  parameter int DW    = 32,
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] wa_i,
  input  logic [DW-1:0] wd_i,
  input  logic [AW-1:0] ra_i,
  output logic [DW-1:0] ra_data_o,
  input  logic [AW-1:0] rb_i,
  output logic [DW-1:0] rb_data_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[wa_i] <= wd_i;
  end

  assign ra_data_o = mem_q[ra_i];
  assign rb_data_o = mem_q[rb_i];

  a_r6_mem_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem_q[$past(wa_i)] == $past(wd_i));
endmodule

// File: rtl/sc_core.sv
module sc_core
  import core_pkg::*;
#(
  parameter int MEM_AW = 8,
  localparam int DEPTH = 1 << MEM_AW,
  localparam int RAW   = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_en_i,
  input  logic              load_sel_i,
  input  logic [MEM_AW-1:0] load_addr_i,
  input  logic [XLEN-1:0]   load_data_i,
  output logic [XLEN-1:0]   pc_o,
  input  logic [RAW-1:0]    dbg_reg_addr_i,
  output logic [XLEN-1:0]   dbg_reg_data_o,
  input  logic [MEM_AW-1:0] dbg_mem_addr_i,
  output logic [XLEN-1:0]   dbg_mem_data_o
);
  logic [XLEN-1:0] pc_q, pc_next, pc_seq;
  logic [XLEN-1:0] instr, imem_dbg, dmem_rd, dmem_dbg;
  logic [XLEN-1:0] rs_data, rt_data, imm_ext, alu_b, alu_y, wb_data;
  logic [RAW-1:0]  rs, rt, rd, wa;
  logic [15:0]     imm;
  logic            alu_zero, take_br, core_mem_we, dmem_we;
  logic [MEM_AW-1:0] dmem_wa;
  logic [XLEN-1:0] dmem_wd;
  ctrl_t           ctrl;

  // fetch
  core_wmem #(.DW(XLEN), .DEPTH(DEPTH)) u_imem (
    .clk_i, .rst_ni,
    .we_i(load_en_i && !load_sel_i), .wa_i(load_addr_i), .wd_i(load_data_i),
    .ra_i(pc_q[MEM_AW+1:2]), .ra_data_o(instr),
    .rb_i(dbg_mem_addr_i), .rb_data_o(imem_dbg)
  );

  assign rs  = instr[25:21];
  assign rt  = instr[20:16];
  assign rd  = instr[15:11];
  assign imm = instr[15:0];

  core_decoder u_dec (
    .clk_i, .rst_ni, .op_i(instr[31:26]), .funct_i(instr[5:0]), .ctrl_o(ctrl)
  );

  assign imm_ext = ctrl.ext_sign ? {{(XLEN-16){imm[15]}}, imm} : {{(XLEN-16){1'b0}}, imm};
  assign wa      = ctrl.dst_rd ? rd : rt;

  core_regfile #(.DW(XLEN), .NREG(1 << RAW)) u_rf (
    .clk_i, .rst_ni,
    .we_i(ctrl.reg_we), .wa_i(wa), .wd_i(wb_data),
    .ra_i(rs), .ra_data_o(rs_data),
    .rb_i(rt), .rb_data_o(rt_data),
    .rc_i(dbg_reg_addr_i), .rc_data_o(dbg_reg_data_o)
  );

  assign alu_b = ctrl.src_imm ? imm_ext : rt_data;

  core_alu #(.DW(XLEN)) u_alu (
    .a_i(rs_data), .b_i(alu_b), .op_i(ctrl.alu_op), .y_o(alu_y), .zero_o(alu_zero)
  );

  // data memory: side port has priority, core stores gated by reset
  assign core_mem_we = ctrl.mem_we && rst_ni && !load_en_i;
  assign dmem_we     = (load_en_i && load_sel_i) || core_mem_we;
  assign dmem_wa     = load_en_i ? load_addr_i : alu_y[MEM_AW+1:2];
  assign dmem_wd     = load_en_i ? load_data_i : rt_data;

  core_wmem #(.DW(XLEN), .DEPTH(DEPTH)) u_dmem (
    .clk_i, .rst_ni,
    .we_i(dmem_we), .wa_i(dmem_wa), .wd_i(dmem_wd),
    .ra_i(alu_y[MEM_AW+1:2]), .ra_data_o(dmem_rd),
    .rb_i(dbg_mem_addr_i), .rb_data_o(dmem_dbg)
  );

  assign wb_data        = ctrl.wb_mem ? dmem_rd : alu_y;
  assign dbg_mem_data_o = load_sel_i ? dmem_dbg : imem_dbg;

  // next PC
  assign take_br = ctrl.branch && alu_zero;
  assign pc_seq  = pc_q + XLEN'(4);
  assign pc_next = take_br ? pc_seq + {imm_ext[XLEN-3:0], 2'b00} : pc_seq;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_next;
  end

  assign pc_o = pc_q;

  a_r10_seq_pc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ctrl.branch && rs_data == rt_data) |=> pc_q == $past(pc_q) + 32'd4);
  a_r7_branch_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl.branch && rs_data == rt_data)
      |=> pc_q == $past(pc_q) + 32'd4 + ($past({{16{imm[15]}}, imm}) << 2));
endmodule

// File: tb/tb_sc_core.sv
module tb_sc_core;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        load_en_i = 1'b0, load_sel_i = 1'b0;
  logic [7:0]  load_addr_i = '0, dbg_mem_addr_i = '0;
  logic [31:0] load_data_i = '0;
  logic [4:0]  dbg_reg_addr_i = '0;
  logic [31:0] pc_o, dbg_reg_data_o, dbg_mem_data_o;

  int n_chk = 0, n_bad = 0;

  always #4 clk_i = ~clk_i;

  sc_core dut (.*);

  localparam int NPROG = 19;
  localparam logic [31:0] PROG [NPROG] = '{
    32'h34018000, // 0  ori  r1,r0,0x8000      R4
    32'h34020010, // 1  ori  r2,r0,0x0010
    32'h00221821, // 2  addu r3,r1,r2          R2
    32'h00412023, // 3  subu r4,r2,r1          R3
    32'h00816021, // 4  addu r12,r4,r1 (wraps) R2
    32'h8C450000, // 5  lw   r5,0(r2)          R5
    32'h8C46FFFC, // 6  lw   r6,-4(r2)         R5
    32'hAC450820, // 7  sw   r5,0x820(r2)      R6
    32'h34201234, // 8  ori  r0,r1,0x1234      R8
    32'h00210021, // 9  addu r0,r1,r1          R8
    32'hFC275555, // 10 unknown opcode         R9
    32'h00225825, // 11 unknown funct          R9
    32'h10220005, // 12 beq r1,r2 not taken    R7
    32'h34080001, // 13 ori r8,r0,1
    32'h10420002, // 14 beq r2,r2,+2 taken     R7
    32'h34090BAD, // 15 skipped
    32'h34090BAD, // 16 skipped
    32'h340A0077, // 17 ori r10,r0,0x77
    32'h1000FFFF  // 18 beq r0,r0,-1 self loop
  };
  localparam int NTRACE = 20;
  localparam int TRACE [NTRACE] = '{0,1,2,3,4,5,6,7,8,9,10,11,12,13,14,17,18,18,18,18};

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_reg(input int r);
    case (r)
      1:  return 32'h00008000;
      2:  return 32'h00000010;
      3:  return 32'h00008010;
      4:  return 32'hFFFF8010;
      5:  return 32'hCAFEF00D;
      6:  return 32'h12345678;
      8:  return 32'h00000001;
      10: return 32'h00000077;
      12: return 32'h00000010;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string reg_req(input int r);
    case (r)
      0: return "R8"; 1: return "R4/R6"; 3: return "R2"; 4: return "R3";
      5, 6, 31: return "R5"; 7, 11: return "R9"; 9: return "R7"; 12: return "R2";
      default: return "R10";
    endcase
  endfunction

  task automatic load_word(input bit sel, input int addr, input logic [31:0] data);
    @(negedge clk_i);
    load_en_i = 1'b1; load_sel_i = sel; load_addr_i = 8'(addr); load_data_i = data;
    @(posedge clk_i);
    #1 load_en_i = 1'b0;
  endtask

  initial begin
    #1;
    check(pc_o == 32'h0, "R1", pc_o, 32'h0);
    dbg_reg_addr_i = 5'd3;
    #1 check(dbg_reg_data_o == 32'h0, "R1", dbg_reg_data_o, 32'h0);

    for (int i = 0; i < NPROG; i++) load_word(1'b0, i, PROG[i]);
    load_word(1'b1, 3, 32'h12345678);
    load_word(1'b1, 4, 32'hCAFEF00D);

    // R11: side-port readback from both memories
    @(negedge clk_i);
    load_sel_i = 1'b0; dbg_mem_addr_i = 8'd6;
    #1 check(dbg_mem_data_o == PROG[6], "R11", dbg_mem_data_o, PROG[6]);
    load_sel_i = 1'b1; dbg_mem_addr_i = 8'd4;
    #1 check(dbg_mem_data_o == 32'hCAFEF00D, "R11", dbg_mem_data_o, 32'hCAFEF00D);
    check(pc_o == 32'h0, "R1", pc_o, 32'h0);

    // run: release reset away from the edge, trace the PC once per cycle
    @(negedge clk_i);
    rst_ni = 1'b1;
    for (int k = 0; k < NTRACE; k++) begin
      #1 check(pc_o == 32'(TRACE[k] * 4), (TRACE[k] > 11) ? "R7" : "R10", pc_o, 32'(TRACE[k] * 4));
      @(negedge clk_i);
    end

    // final register file
    for (int r = 0; r < 32; r++) begin
      dbg_reg_addr_i = 5'(r);
      #1 check(dbg_reg_data_o == exp_reg(r), reg_req(r), dbg_reg_data_o, exp_reg(r));
    end

    // final data memory
    dbg_mem_addr_i = 8'd12;
    #1 check(dbg_mem_data_o == 32'hCAFEF00D, "R6", dbg_mem_data_o, 32'hCAFEF00D);
    dbg_mem_addr_i = 8'd3;
    #1 check(dbg_mem_data_o == 32'h12345678, "R6", dbg_mem_data_o, 32'h12345678);
    dbg_mem_addr_i = 8'd4;
    #1 check(dbg_mem_data_o == 32'hCAFEF00D, "R6", dbg_mem_data_o, 32'hCAFEF00D);

    // R1: asynchronous reset mid-run
    @(posedge clk_i);
    #2 rst_ni = 1'b0;
    #1 check(pc_o == 32'h0, "R1", pc_o, 32'h0);
    dbg_reg_addr_i = 5'd5;
    #1 check(dbg_reg_data_o == 32'h0, "R1", dbg_reg_data_o, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %08h expected %08h", 32'h1, 32'h0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule